// File: doc/BRIEF.md
# Page-Walk Request Filter with Load Hints

This block collects translation misses from several data-side TLB requesters and forwards them, one at a time, to a single shared page-table-walker port. Requesters are split into three groups: load, store and prefetch. Each group owns its own filter queue: 16 load entries, 8 store entries and 8 prefetch entries. A miss whose virtual page number (VPN) is already held in its group is merged into the existing entry, so each page is walked only once. Walks are issued oldest-first, and an entry is never sent twice.

Each load port gets a registered hint one cycle after its request. The hint is either the id of the load entry that now holds the miss, or a full flag telling the load to replay at once. When a walker response arrives it is held in a register for one cycle. It then frees every entry it covers and produces a wakeup pulse that carries the lowest covered load entry id. The pulse also carries a replay-all bit, set when a 2M or 1G result covers several separately walked 4K pages. A fence or a change of the translation root empties every queue. Address-space ids take no part in any comparison.

Top module: `ptw_hint_filter`

## Requirements
- R1: After reset, no walk request is presented, every load hint reads id 0 with full clear, and no wakeup is signalled.
- R2: A load request that finds no matching entry and a free load slot takes the lowest-numbered free load entry. The cycle after the request, its port shows that entry id (0 to 15) with full clear.
- R3: A request whose VPN equals a valid entry of the same group allocates nothing and causes no extra walk. A load request merged this way gets the existing entry id in its hint.
- R4: A load request that neither merges nor finds a free slot gets full set and id 0 in its hint. Store and prefetch requests in that situation are dropped silently.
- R5: The walk request shows the oldest unsent entry and stays unchanged until ready is high. Entries allocated in the same cycle rank as load port 0, then the other load ports in order, then store, then prefetch. Each entry is walked at most once.
- R6: A walker response takes effect the cycle after it is accepted. A response that arrives while the fence or root-change input is high is discarded.
- R7: A response level of 0 compares all VPN bits. Level 1 ignores the low 9 bits, and levels 2 and 3 ignore the low 18 bits. Every covered entry in every group is freed.
- R8: The wakeup pulse fires when the held response covers at least one load entry. It carries the lowest covered load id, and replay-all is set when more than one load entry is covered.
- R9: A request is dropped when the held response is valid, its group mask has the request's group bit set (bit 0 load, bit 1 store, bit 2 prefetch), and it covers the request's VPN. A dropped load sees full set the next cycle.
- R10: A fence or root change clears all entries with no wakeup for them. Requests in that cycle are dropped, and load requests get full set.
- R11: The walker response ready output is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fence | input | 1 | Translation fence; empties the filter |
| root_chg | input | 1 | Translation root changed; empties the filter |
| ld_req_vld | input | NLD | Load miss valid, one bit per port |
| ld_req_vpn | input | NLD*VPN_W | Load miss VPNs, port p at bits p*VPN_W |
| st_req_vld | input | 1 | Store miss valid |
| st_req_vpn | input | VPN_W | Store miss VPN |
| pf_req_vld | input | 1 | Prefetch miss valid |
| pf_req_vpn | input | VPN_W | Prefetch miss VPN |
| walk_req_vld | output | 1 | Walk request valid |
| walk_req_vpn | output | VPN_W | Walk request VPN |
| walk_req_rdy | input | 1 | Walker accepts the request |
| walk_rsp_vld | input | 1 | Walker response valid |
| walk_rsp_vpn | input | VPN_W | Response VPN |
| walk_rsp_lvl | input | 2 | Page size: 0 = 4K, 1 = 2M, 2 or 3 = 1G |
| walk_rsp_grp | input | 3 | Target groups: bit 0 load, bit 1 store, bit 2 prefetch |
| walk_rsp_rdy | output | 1 | Always high |
| ld_hint_id | output | NLD*IDW | Per-port entry id, registered |
| ld_hint_full | output | NLD | Per-port replay-now flag, registered |
| wake_vld | output | 1 | Wakeup pulse |
| wake_id | output | IDW | Lowest covered load entry id |
| wake_all | output | 1 | More than one load entry covered |

## Verification
A fill phase sends twenty distinct VPNs on both load ports while the walker is stalled. This separates lowest-free allocation from the full flag, and it checks that issue order follows allocation order and not slot number. A single 2M response then covers every waiting entry, which triggers replay-all. A targeted response followed by a load to the same page shows the drop path forcing full. The long random phase draws VPNs from 64 values spread across 4K, 2M and 1G boundaries, with random response levels, group masks, ready stalls and rare fences. That mix tells merging apart from re-allocation, separates a huge-page cover from an exact match, and shows whether a fence in the same cycle discards the response as well as the entries.

// File: rtl/ptw_hint_filter.sv
module ptw_hint_filter #(
  parameter int NLD      = 2,
  parameter int LD_N     = 16,
  parameter int ST_N     = 8,
  parameter int PF_N     = 8,
  parameter int VPN_W    = 27,
  parameter int LVL_BITS = 9,
  parameter int STAMP_W  = 32,
  localparam int IDW     = $clog2(LD_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fence,
  input  logic                 root_chg,
  input  logic [NLD-1:0]       ld_req_vld,
  input  logic [NLD*VPN_W-1:0] ld_req_vpn,
  input  logic                 st_req_vld,
  input  logic [VPN_W-1:0]     st_req_vpn,
  input  logic                 pf_req_vld,
  input  logic [VPN_W-1:0]     pf_req_vpn,
  output logic                 walk_req_vld,
  output logic [VPN_W-1:0]     walk_req_vpn,
  input  logic                 walk_req_rdy,
  input  logic                 walk_rsp_vld,
  input  logic [VPN_W-1:0]     walk_rsp_vpn,
  input  logic [1:0]           walk_rsp_lvl,
  input  logic [2:0]           walk_rsp_grp,
  output logic                 walk_rsp_rdy,
  output logic [NLD*IDW-1:0]   ld_hint_id,
  output logic [NLD-1:0]       ld_hint_full,
  output logic                 wake_vld,
  output logic [IDW-1:0]       wake_id,
  output logic                 wake_all
);
  localparam int N     = LD_N + ST_N + PF_N;
  localparam int NR    = NLD + 2;
  localparam int ST_LO = LD_N;
  localparam int PF_LO = LD_N + ST_N;

  function automatic logic covers(input logic [VPN_W-1:0] a, input logic [VPN_W-1:0] b,
                                  input logic [1:0] lvl);
    logic [VPN_W-1:0] m;
    m = '1;
    if (lvl == 2'd1) m = m << LVL_BITS;
    else if (lvl[1]) m = m << (2 * LVL_BITS);
    return ((a ^ b) & m) == '0;
  endfunction

  function automatic int grp_of(input int i);
    return (i < ST_LO) ? 0 : ((i < PF_LO) ? 1 : 2);
  endfunction

  logic [N-1:0]         ev, es, nv, ns;
  logic [VPN_W-1:0]     evpn [N];
  logic [VPN_W-1:0]     nvpn [N];
  logic [STAMP_W-1:0]   stamp [N];
  logic [STAMP_W-1:0]   nstamp [N];
  logic [STAMP_W-1:0]   now;
  logic                 rq_vld;
  logic [VPN_W-1:0]     rq_vpn;
  logic [1:0]           rq_lvl;
  logic [2:0]           rq_grp;
  logic [NLD*IDW-1:0]   hid_d;
  logic [NLD-1:0]       hfull_d;
  logic [NR-1:0]        req_v;
  logic [VPN_W-1:0]     req_a [NR];
  logic                 pick_f;
  int                   pick_i;

  wire flush = fence | root_chg;
  assign walk_rsp_rdy = 1'b1;

  for (genvar p = 0; p < NLD; p++) begin : g_ldreq
    assign req_v[p] = ld_req_vld[p];
    assign req_a[p] = ld_req_vpn[p*VPN_W +: VPN_W];
  end
  assign req_v[NLD]   = st_req_vld;
  assign req_a[NLD]   = st_req_vpn;
  assign req_v[NLD+1] = pf_req_vld;
  assign req_a[NLD+1] = pf_req_vpn;

  always_comb begin
    pick_f = 1'b0;
    pick_i = 0;
    for (int i = 0; i < N; i++)
      if (ev[i] && !es[i] && (!pick_f || stamp[i] < stamp[pick_i])) begin
        pick_f = 1'b1;
        pick_i = i;
      end
  end
  assign walk_req_vld = pick_f;
  assign walk_req_vpn = pick_f ? evpn[pick_i] : '0;

  always_comb begin
    int cnt;
    cnt = 0;
    wake_id = '0;
    for (int i = LD_N - 1; i >= 0; i--)
      if (ev[i] && covers(evpn[i], rq_vpn, rq_lvl)) begin
        wake_id = IDW'(i);
        cnt++;
      end
    wake_vld = rq_vld && !flush && (cnt != 0);
    wake_all = wake_vld && (cnt > 1);
    if (!wake_vld) wake_id = '0;
  end

  always_comb begin
    int g, hit_i, free_i;
    logic hit, free, drop;
    nv = ev; ns = es; nvpn = evpn; nstamp = stamp;
    hid_d = '0; hfull_d = '0;
    if (pick_f && walk_req_rdy) ns[pick_i] = 1'b1;
    if (rq_vld)
      for (int i = 0; i < N; i++)
        if (ev[i] && covers(evpn[i], rq_vpn, rq_lvl)) nv[i] = 1'b0;
    for (int r = 0; r < NR; r++) begin
      g = (r < NLD) ? 0 : ((r == NLD) ? 1 : 2);
      hit = 1'b0; free = 1'b0; hit_i = 0; free_i = 0;
      drop = flush || (rq_vld && rq_grp[g] && covers(req_a[r], rq_vpn, rq_lvl));
      for (int i = 0; i < N; i++)
        if (grp_of(i) == g) begin
          if (nv[i] && nvpn[i] == req_a[r] && !hit) begin hit = 1'b1; hit_i = i; end
          if (!nv[i] && !free) begin free = 1'b1; free_i = i; end
        end
      if (req_v[r] && !drop && !hit && free) begin
        nv[free_i] = 1'b1; ns[free_i] = 1'b0;
        nvpn[free_i] = req_a[r]; nstamp[free_i] = now;
      end
      if (r < NLD && req_v[r]) begin
        if (drop || (!hit && !free)) hfull_d[r] = 1'b1;
        else hid_d[r*IDW +: IDW] = IDW'(hit ? hit_i : free_i);
      end
    end
    if (flush) nv = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev <= '0; es <= '0; now <= '0;
      rq_vld <= 1'b0; rq_vpn <= '0; rq_lvl <= '0; rq_grp <= '0;
      hid_q <= '0; hfull_q <= '0;
      for (int i = 0; i < N; i++) begin evpn[i] <= '0; stamp[i] <= '0; end
    end else begin
      ev <= nv; es <= ns; now <= now + 1'b1;
      evpn <= nvpn; stamp <= nstamp;
      rq_vld <= walk_rsp_vld && !flush;
      rq_vpn <= walk_rsp_vpn; rq_lvl <= walk_rsp_lvl; rq_grp <= walk_rsp_grp;
      hid_q <= hid_d; hfull_q <= hfull_d;
    end
  end

  logic [NLD*IDW-1:0] hid_q;
  logic [NLD-1:0]     hfull_q;
  assign ld_hint_id   = hid_q;
  assign ld_hint_full = hfull_q;

  assert_wake_after_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vld |-> $past(walk_rsp_vld));
  assert_fence_discards_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !wake_vld);
  assert_fence_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !walk_req_vld);
  assert_all_needs_huge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_all |-> $past(walk_rsp_lvl) != 2'd0);
  assert_hold_until_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_vld && !walk_req_rdy && !flush && !rq_vld) |=> (walk_req_vld && $stable(walk_req_vpn)));
  for (genvar p = 0; p < NLD; p++) begin : g_drop_chk
    assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req_vld[p] && rq_vld && rq_grp[0] &&
       covers(ld_req_vpn[p*VPN_W +: VPN_W], rq_vpn, rq_lvl)) |=> ld_hint_full[p]);
  end
endmodule

// File: tb/ptw_hint_filter_tb.sv
`timescale 1ns/1ps
module ptw_hint_filter_tb_top;
  localparam int NLD = 2, VPN_W = 27, IDW = 4, NE = 32;
  localparam int GLO [3] = '{0, 16, 24};
  localparam int GHI [3] = '{16, 24, 32};

  logic clk = 1'b0, rst_n = 1'b0;
  logic fence = 0, root_chg = 0;
  logic [NLD-1:0] ld_req_vld = '0;
  logic [NLD*VPN_W-1:0] ld_req_vpn = '0;
  logic st_req_vld = 0, pf_req_vld = 0;
  logic [VPN_W-1:0] st_req_vpn = '0, pf_req_vpn = '0;
  logic walk_req_vld, walk_rsp_rdy, wake_vld, wake_all;
  logic [VPN_W-1:0] walk_req_vpn;
  logic walk_req_rdy = 0, walk_rsp_vld = 0;
  logic [VPN_W-1:0] walk_rsp_vpn = '0;
  logic [1:0] walk_rsp_lvl = '0;
  logic [2:0] walk_rsp_grp = '0;
  logic [NLD*IDW-1:0] ld_hint_id;
  logic [NLD-1:0] ld_hint_full;
  logic [IDW-1:0] wake_id;

  always #2.5 clk = ~clk;

  ptw_hint_filter dut_i (.*);

  int checks = 0, fails = 0;
  bit m_v [NE], m_s [NE];
  int m_vpn [NE];
  int q [$];
  int pend [$];
  bit m_rqv = 0; int m_rqvpn = 0, m_rqlvl = 0, m_rqgrp = 0;
  int e_hid [NLD], e_hfull [NLD];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic bit cov(input int a, input int b, input int lvl);
    int m;
    m = (lvl == 0) ? 32'h7ffffff : (lvl == 1) ? 32'h7fffe00 : 32'h7fc0000;
    return ((a ^ b) & m) == 0;
  endfunction

  task automatic step();
    bit flush, ewv, drop, hit, fr;
    int esel, wid, wcnt, g, vpn, hi, fi;
    bit rv;
    #1;
    flush = fence | root_chg;
    ewv = 0; esel = 0;
    foreach (q[k]) if (!ewv && !m_s[q[k]]) begin ewv = 1; esel = q[k]; end
    wid = 0; wcnt = 0;
    if (m_rqv && !flush)
      for (int i = 0; i < 16; i++)
        if (m_v[i] && cov(m_vpn[i], m_rqvpn, m_rqlvl)) begin if (wcnt == 0) wid = i; wcnt++; end
    chk(walk_req_vld == ewv, "R5 walk_req_vld", walk_req_vld, ewv);
    if (ewv) chk(walk_req_vpn == VPN_W'(m_vpn[esel]), "R5/R3 walk_req_vpn", walk_req_vpn, m_vpn[esel]);
    chk(wake_vld == (wcnt > 0), "R6/R7/R8 wake_vld", wake_vld, wcnt > 0);
    if (wcnt > 0) begin
      chk(wake_id == IDW'(wid), "R8 wake_id", wake_id, wid);
      chk(wake_all == (wcnt > 1), "R8/R7 wake_all", wake_all, wcnt > 1);
    end
    chk(walk_rsp_rdy == 1'b1, "R11 walk_rsp_rdy", walk_rsp_rdy, 1);
    for (int p = 0; p < NLD; p++) begin
      chk(ld_hint_full[p] == e_hfull[p][0], "R2/R4/R9/R10 ld_hint_full", ld_hint_full[p], e_hfull[p]);
      chk(ld_hint_id[p*IDW +: IDW] == IDW'(e_hid[p]), "R2/R3 ld_hint_id",
          ld_hint_id[p*IDW +: IDW], e_hid[p]);
    end
    if (ewv && walk_req_rdy && !flush) begin m_s[esel] = 1; pend.push_back(m_vpn[esel]); end
    if (m_rqv)
      for (int i = 0; i < NE; i++) if (m_v[i] && cov(m_vpn[i], m_rqvpn, m_rqlvl)) m_v[i] = 0;
    begin
      int nq [$];
      foreach (q[k]) if (m_v[q[k]]) nq.push_back(q[k]);
      q = nq;
    end
    for (int r = 0; r < NLD + 2; r++) begin
      g = (r < NLD) ? 0 : (r == NLD) ? 1 : 2;
      rv  = (r < NLD) ? ld_req_vld[r] : (r == NLD) ? st_req_vld : pf_req_vld;
      vpn = (r < NLD) ? int'(ld_req_vpn[r*VPN_W +: VPN_W]) : (r == NLD) ? int'(st_req_vpn) : int'(pf_req_vpn);
      if (r < NLD) begin e_hid[r] = 0; e_hfull[r] = 0; end
      if (rv) begin
        drop = flush || (m_rqv && m_rqgrp[g] && cov(vpn, m_rqvpn, m_rqlvl));
        hit = 0; fr = 0; hi = 0; fi = 0;
        for (int i = GLO[g]; i < GHI[g]; i++) begin
          if (m_v[i] && m_vpn[i] == vpn && !hit) begin hit = 1; hi = i; end
          if (!m_v[i] && !fr) begin fr = 1; fi = i; end
        end
        if (!drop && !hit && fr) begin m_v[fi] = 1; m_s[fi] = 0; m_vpn[fi] = vpn; q.push_back(fi); end
        if (r < NLD) begin
          if (drop || (!hit && !fr)) e_hfull[r] = 1;
          else e_hid[r] = hit ? hi : fi;
        end
      end
    end
    if (flush) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
      q.delete();
    end
    m_rqv = walk_rsp_vld && !flush;
    m_rqvpn = int'(walk_rsp_vpn); m_rqlvl = int'(walk_rsp_lvl); m_rqgrp = int'(walk_rsp_grp);
    @(negedge clk);
  endtask

  task automatic idle();
    ld_req_vld = '0; st_req_vld = 0; pf_req_vld = 0;
    walk_rsp_vld = 0; fence = 0; root_chg = 0;
  endtask

  function automatic int rvpn();
    return (($urandom % 4) << 18) | (($urandom % 4) << 9) | ($urandom % 4);
  endfunction

  bit done = 0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NLD; p++) begin e_hid[p] = 0; e_hfull[p] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(walk_req_vld == 0, "R1 reset walk_req_vld", walk_req_vld, 0);
    chk(wake_vld == 0, "R1 reset wake_vld", wake_vld, 0);
    chk(ld_hint_full == '0, "R1 reset ld_hint_full", ld_hint_full, 0);
    chk(ld_hint_id == '0, "R1 reset ld_hint_id", ld_hint_id, 0);
    @(negedge clk);
    // fill load filter past capacity with the walker stalled
    for (int k = 0; k < 10; k++) begin
      idle();
      ld_req_vld = 2'b11;
      ld_req_vpn = {VPN_W'(2*k+1), VPN_W'(2*k)};
      walk_req_rdy = (k % 3 == 0);
      step();
    end
    // merge onto an existing entry
    idle(); ld_req_vld = 2'b01; ld_req_vpn = {VPN_W'(0), VPN_W'(5)}; step();
    // one 2M response covers all waiting loads: replay-all
    idle(); walk_req_rdy = 1; walk_rsp_vld = 1; walk_rsp_vpn = '0; walk_rsp_lvl = 2'd1;
    walk_rsp_grp = 3'b111; step();
    // exact-page response, then a load to that page the next cycle is dropped
    idle(); walk_rsp_vld = 1; walk_rsp_vpn = VPN_W'(27'h40201); walk_rsp_lvl = 0;
    walk_rsp_grp = 3'b001; step();
    idle(); ld_req_vld = 2'b10; ld_req_vpn = {VPN_W'(27'h40201), VPN_W'(0)}; step();
    idle(); step(); step();
    // random mixed traffic
    for (int c = 0; c < 3000; c++) begin
      idle();
      for (int p = 0; p < NLD; p++) begin
        ld_req_vld[p] = ($urandom % 100) < 35;
        ld_req_vpn[p*VPN_W +: VPN_W] = VPN_W'(rvpn());
      end
      st_req_vld = ($urandom % 100) < 25; st_req_vpn = VPN_W'(rvpn());
      pf_req_vld = ($urandom % 100) < 20; pf_req_vpn = VPN_W'(rvpn());
      walk_req_rdy = ($urandom % 100) < 60;
      if (($urandom % 100) < 25) begin
        walk_rsp_vld = 1;
        walk_rsp_vpn = (pend.size() > 0 && ($urandom % 2)) ? VPN_W'(pend.pop_front()) : VPN_W'(rvpn());
        case ($urandom % 5) 0, 1, 2: walk_rsp_lvl = 0; 3: walk_rsp_lvl = 1; default: walk_rsp_lvl = 2'($urandom % 2 + 2); endcase
        walk_rsp_grp = (($urandom % 2) != 0) ? 3'b111 : 3'($urandom % 8);
      end
      fence = ($urandom % 250) == 0;
      root_chg = ($urandom % 300) == 0;
      step();
    end
    idle(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule